// File: doc/BRIEF.md
# Comma-Detect Character Framer

This block takes a recovered serial stream, one bit per clock, and cuts it into 10-bit transmission characters. Each clock the newest bit joins a ten-bit sliding window. A pattern matcher looks in that window for a framing pattern, and configuration picks which pattern counts. When a pattern is found at an offset other than the current character boundary, an alignment controller decides whether to move the boundary there. It can move at once, or only after the same offset has been seen a second time.

Characters leave in parallel, one strobe every ten bits. The first bit received is the most significant bit of the character. Status outputs give a one-cycle pulse when the boundary moves and a level that shows whether the link is in sync. Each channel of a multi-channel receiver uses its own instance, with its own configuration.

Top module: `fr_comma_framer`

## Requirements
- R1: While reset is asserted, char_vld, comma_det, frame_evt and in_sync are 0. After reset the boundary offset is zero: the first char_vld comes on the clock edge that shifts in the tenth bit, and then on every tenth edge after it.
- R2: Each delivered character holds the last ten bits received. The earliest of them is at char_out[9] and the newest at char_out[0]. char_vld is high for exactly one cycle per delivered character.
- R3: pat_sel picks the framing pattern, compared against the window in received order. 2'b00 matches the positive comma 0011111 in the first seven bits of the window. 2'b01 matches either 0011111 or 1100000 there. 2'b10 and 2'b11 match only the whole character 0011111010 or 1100000101.
- R4: When multi_en is 0 and frame_en is 1, a pattern that ends off the current boundary moves the boundary at once. The next character then ends ten bits after the pattern.
- R5: When multi_en is 1, the boundary moves only on the second of two patterns found at the same new offset, a whole number of characters apart. A pattern at any other offset in between restarts the search, and no move happens.
- R6: When multi_en is 1 and frame_en is 1, a pattern off the current boundary that does not confirm a move clears in_sync on that edge.
- R7: When low_lat is 1, a boundary move also delivers the pattern character itself on the same edge. When low_lat is 0, no character is delivered on the move, and the first new character comes ten bits later.
- R8: comma_det is high with a delivered character whose window matches the pattern. A match at the current boundary leaves the boundary unchanged.
- R9: frame_evt pulses for one cycle on each edge where the boundary moves, and at no other time.
- R10: in_sync is 0 after reset. It becomes 1 when the boundary moves, or when a pattern is accepted at the current boundary while frame_en is 1. It holds that value until R6 clears it or reset is applied.
- R11: When frame_en is 0, the boundary is held and in_sync does not change, whatever patterns arrive. comma_det still reports matches at the held boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_in | input | 1 | Serial data bit, one per clock |
| pat_sel | input | 2 | Framing pattern select |
| multi_en | input | 1 | 1 = two-pattern confirmation before a move |
| low_lat | input | 1 | 1 = deliver the pattern character on the move |
| frame_en | input | 1 | 1 = boundary may move |
| char_out | output | 10 | Aligned character, earliest bit at bit 9 |
| char_vld | output | 1 | Character strobe |
| comma_det | output | 1 | Delivered character holds the pattern |
| frame_evt | output | 1 | Boundary moved on this edge |
| in_sync | output | 1 | Framing accepted and not since contradicted |

## Verification
The assertions assume the configuration inputs hold steady between resets. They also assume that a status flag relates to the configuration one edge earlier. If the mode changed in the middle of a character, the relation between the candidate phase and the boundary phase would lose its meaning. The stimulus therefore sets every mode input before reset is released and leaves it alone for the whole stream.

The filler between patterns alternates 0 and 1. No run of five equal bits can then form outside a placed pattern, so every match the bench expects comes from a character it inserted on purpose.

// File: rtl/fr_pkg.sv
package fr_pkg;
   localparam int FR_CHAR_W  = 10;
   localparam int FR_COMMA_W = 7;

   typedef enum logic [1:0] {
      PAT_POS  = 2'b00,
      PAT_ANY  = 2'b01,
      PAT_FULL = 2'b10,
      PAT_FALT = 2'b11
   } pat_sel_e;
endpackage

// File: rtl/fr_match.sv
module fr_match
   import fr_pkg::*;
#(
   parameter int CHAR_W        = FR_CHAR_W,
   parameter int COMMA_W       = FR_COMMA_W,
   parameter logic [COMMA_W-1:0] POS_COMMA = 7'b0011111,
   parameter logic [CHAR_W-1:0]  POS_CHAR  = 10'b0011111010,
   parameter bit FULL_CHAR_EN  = 1'b1
) (
   input  logic [CHAR_W-1:0] win,
   input  logic [1:0]        pat_sel,
   output logic              hit,
   output logic              pos_c,
   output logic              neg_c
);
   logic full_c;

   // earliest bit sits at the top of the window
   assign pos_c = (win[CHAR_W-1 -: COMMA_W] == POS_COMMA);
   assign neg_c = (win[CHAR_W-1 -: COMMA_W] == ~POS_COMMA);

   generate
      if (FULL_CHAR_EN) begin : g_full
         assign full_c = (win == POS_CHAR) || (win == ~POS_CHAR);
      end else begin : g_nofull
         assign full_c = pos_c || neg_c;
      end
   endgenerate

   always_comb begin
      case (pat_sel_e'(pat_sel))
         PAT_POS: hit = pos_c;
         PAT_ANY: hit = pos_c || neg_c;
         default: hit = full_c;
      endcase
   end
endmodule

// File: rtl/fr_align.sv
module fr_align
   import fr_pkg::*;
#(
   parameter int CHAR_W = FR_CHAR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_en,
   input  logic              multi_en,
   input  logic              low_lat,
   input  logic              hit,
   input  logic [CHAR_W-1:0] win_n,
   output logic [CHAR_W-1:0] char_q,
   output logic              char_vld,
   output logic              comma_det,
   output logic              frame_evt,
   output logic              in_sync
);
   localparam int CNT_W = $clog2(CHAR_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAR_W - 1);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;   // bits since boundary
   logic [CNT_W-1:0] cph_q;   // bits since candidate, modulo CHAR_W
   logic             cand_q;
   logic at_bnd, off_hit, confirm, move, conflict, deliver;

   always_comb begin
      at_bnd   = (cnt_q == LAST);
      off_hit  = hit && !at_bnd && frame_en;
      confirm  = off_hit && multi_en && cand_q && (cph_q == LAST);
      move     = off_hit && (!multi_en || confirm);
      conflict = off_hit && multi_en && !confirm;
      deliver  = at_bnd || (move && low_lat);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         cph_q     <= '0;
         cand_q    <= 1'b0;
         char_q    <= '0;
         char_vld  <= 1'b0;
         comma_det <= 1'b0;
         frame_evt <= 1'b0;
         in_sync   <= 1'b0;
      end else begin
         cnt_q <= (at_bnd || move) ? '0 : cnt_q + ONE;
         cph_q <= (conflict || cph_q == LAST) ? '0 : cph_q + ONE;
         if (!frame_en || !multi_en)  cand_q <= 1'b0;
         else if (conflict)           cand_q <= 1'b1;
         else if (move)               cand_q <= 1'b0;
         else if (hit && at_bnd)      cand_q <= 1'b0;
         char_vld  <= deliver;
         if (deliver) char_q <= win_n;
         comma_det <= deliver && hit;
         frame_evt <= move;
         if (move || (hit && at_bnd && frame_en)) in_sync <= 1'b1;
         else if (conflict)                      in_sync <= 1'b0;
      end
   end

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);                                          // R2
   AST_VLD_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      char_vld |-> cnt_q == '0);                               // R2
   AST_CD_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
      comma_det |-> char_vld);                                 // R8
   AST_EVT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      frame_evt |-> $past(frame_en));                          // R11
   AST_EVT_SYNCS: assert property (@(posedge clk) disable iff (!rst_n)
      frame_evt |-> in_sync);                                  // R10
   AST_SYNC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_sync) |-> $past(multi_en) && $past(frame_en));  // R6
   AST_CAND_MULTI: assert property (@(posedge clk) disable iff (!rst_n)
      cand_q |-> $past(multi_en));                             // R5
endmodule

// File: rtl/fr_comma_framer.sv
module fr_comma_framer
   import fr_pkg::*;
#(
   parameter int CHAR_W       = FR_CHAR_W,
   parameter int COMMA_W      = FR_COMMA_W,
   parameter bit FULL_CHAR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_in,
   input  logic [1:0]        pat_sel,
   input  logic              multi_en,
   input  logic              low_lat,
   input  logic              frame_en,
   output logic [CHAR_W-1:0] char_out,
   output logic              char_vld,
   output logic              comma_det,
   output logic              frame_evt,
   output logic              in_sync
);
   generate
      if (COMMA_W >= CHAR_W) begin : g_bad_comma
         $error("comma width must be below character width");
      end
      if (CHAR_W < 4) begin : g_bad_char
         $error("character width too small");
      end
   endgenerate

   logic [CHAR_W-1:0] win_q, win_n;
   logic hit, pos_c, neg_c;

   assign win_n = {win_q[CHAR_W-2:0], bit_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) win_q <= '0;
      else        win_q <= win_n;
   end

   fr_match #(
      .CHAR_W(CHAR_W), .COMMA_W(COMMA_W), .FULL_CHAR_EN(FULL_CHAR_EN)
   ) u_match (
      .win(win_n), .pat_sel(pat_sel), .hit(hit), .pos_c(pos_c), .neg_c(neg_c)
   );

   fr_align #(.CHAR_W(CHAR_W)) u_align (
      .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .multi_en(multi_en),
      .low_lat(low_lat), .hit(hit), .win_n(win_n), .char_q(char_out),
      .char_vld(char_vld), .comma_det(comma_det), .frame_evt(frame_evt),
      .in_sync(in_sync)
   );

   AST_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pos_c, neg_c}));                               // R3
   AST_POS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (pat_sel == PAT_POS && hit) |-> pos_c);                  // R3
   AST_FULL_NEEDS_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
      (pat_sel[1] && hit) |-> (pos_c || neg_c));               // R3
endmodule

// File: tb/fr_comma_framer_tb.sv
module fr_comma_framer_tb;
   localparam int NB = 80;
   localparam logic [9:0] K28P = 10'b0011111010;
   localparam logic [9:0] K28N = 10'b1100000101;
   localparam logic [9:0] CPOS = 10'b0011111001;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n = 1'b0, bit_in = 1'b0, multi_en = 1'b0, low_lat = 1'b0, frame_en = 1'b1;
   logic [1:0] pat_sel = 2'b00;
   logic [9:0] char_out;
   logic char_vld, comma_det, frame_evt, in_sync;

   int errs = 0, checks = 0;
   logic sbits [0:NB-1];
   logic o_vld [1:NB];
   logic o_cd  [1:NB];
   logic o_evt [1:NB];
   logic o_syn [1:NB];
   logic [9:0] o_chr [1:NB];

   fr_comma_framer u_dut (
      .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .pat_sel(pat_sel),
      .multi_en(multi_en), .low_lat(low_lat), .frame_en(frame_en),
      .char_out(char_out), .char_vld(char_vld), .comma_det(comma_det),
      .frame_evt(frame_evt), .in_sync(in_sync)
   );

   task automatic build(input int p1, input int p2, input int p3, input logic [9:0] c);
      for (int i = 0; i < NB; i++) sbits[i] = logic'(i % 2);
      for (int j = 0; j < 10; j++) begin
         if (p1 >= 0) sbits[p1+j] = c[9-j];
         if (p2 >= 0) sbits[p2+j] = c[9-j];
         if (p3 >= 0) sbits[p3+j] = c[9-j];
      end
   endtask

   function automatic logic exp_vld(input int n, input int r, input logic ll);
      if (r == 0 || n < r) return (n % 10 == 0);
      if (n == r) return ll;
      return ((n - r) % 10 == 0);
   endfunction

   task automatic run_case(input string tag, input logic [1:0] ps, input logic me,
                           input logic ll, input logic fe,
                           input int r, input int d, input int s, input int o);
      logic [9:0] ec;
      logic ev, es;
      pat_sel = ps; multi_en = me; low_lat = ll; frame_en = fe;
      rst_n = 1'b0; bit_in = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      checks++;
      if (char_vld || comma_det || frame_evt || in_sync) begin
         errs++;
         $display("FAIL R1 %s reset state act=%b%b%b%b exp=0000", tag,
                  char_vld, comma_det, frame_evt, in_sync);
      end
      rst_n = 1'b1;
      for (int n = 1; n <= NB; n++) begin
         bit_in = sbits[n-1];
         @(posedge clk);
         #1;
         o_vld[n] = char_vld; o_cd[n] = comma_det; o_evt[n] = frame_evt;
         o_syn[n] = in_sync; o_chr[n] = char_out;
      end
      for (int n = 1; n <= NB; n++) begin
         ev = exp_vld(n, r, ll);
         checks++;
         if (o_vld[n] !== ev) begin
            errs++;
            $display("FAIL %s R2 vld edge %0d act=%b exp=%b", tag, n, o_vld[n], ev);
         end
         if (ev && n >= 10) begin
            for (int j = 0; j < 10; j++) ec[9-j] = sbits[n-10+j];
            checks++;
            if (o_chr[n] !== ec) begin
               errs++;
               $display("FAIL %s R2 char edge %0d act=%b exp=%b", tag, n, o_chr[n], ec);
            end
         end
         checks++;
         if (o_cd[n] !== (d != 0 && n == d)) begin
            errs++;
            $display("FAIL %s R8 comma_det edge %0d act=%b exp=%b", tag, n, o_cd[n], (d != 0 && n == d));
         end
         checks++;
         if (o_evt[n] !== (r != 0 && n == r)) begin
            errs++;
            $display("FAIL %s R9 frame_evt edge %0d act=%b exp=%b", tag, n, o_evt[n], (r != 0 && n == r));
         end
         es = (s != 0 && n >= s && (o == 0 || n < o));
         checks++;
         if (o_syn[n] !== es) begin
            errs++;
            $display("FAIL %s R10 in_sync edge %0d act=%b exp=%b", tag, n, o_syn[n], es);
         end
      end
   endtask

   initial begin
      // R4 / R7: single-character rule, pattern swept over every offset
      for (int k = 0; k < 10; k++) begin
         for (int l = 0; l < 2; l++) begin
            build(k, -1, -1, K28P);
            run_case(l == 1 ? "R7" : "R4", 2'b00, 1'b0, logic'(l), 1'b1,
                     k == 0 ? 0 : k + 10,
                     k == 0 ? 10 : (l == 1 ? k + 10 : 0),
                     k == 0 ? 10 : k + 10, 0);
         end
      end
      // R5: confirmation two characters apart
      for (int k = 1; k < 10; k++) begin
         build(k, k + 20, -1, K28P);
         run_case("R5", 2'b01, 1'b1, 1'b1, 1'b1, k + 30, k + 30, k + 30, 0);
      end
      // R5: pattern at another offset in between restarts the search
      build(2, 17, 32, K28P);
      run_case("R5", 2'b01, 1'b1, 1'b1, 1'b1, 0, 0, 0, 0);
      // R6: conflicting offset after sync clears in_sync
      build(3, 13, 38, K28P);
      run_case("R6", 2'b00, 1'b1, 1'b0, 1'b1, 23, 0, 23, 48);
      // R8: after a move, the next pattern sits on the boundary
      build(3, 13, -1, K28P);
      run_case("R8", 2'b00, 1'b0, 1'b0, 1'b1, 13, 23, 13, 0);
      // R11: framing disabled
      build(4, -1, -1, K28P);
      run_case("R11", 2'b00, 1'b0, 1'b1, 1'b0, 0, 0, 0, 0);
      build(0, -1, -1, K28P);
      run_case("R11", 2'b00, 1'b0, 1'b1, 1'b0, 0, 10, 0, 0);
      // R3: pattern selection
      build(5, -1, -1, K28N);
      run_case("R3", 2'b00, 1'b0, 1'b1, 1'b1, 0, 0, 0, 0);
      for (int p = 1; p < 4; p++) begin
         build(5, -1, -1, K28N);
         run_case("R3", 2'(p), 1'b0, 1'b1, 1'b1, 15, 15, 15, 0);
      end
      for (int p = 0; p < 4; p++) begin
         build(5, -1, -1, CPOS);
         if (p < 2) run_case("R3", 2'(p), 1'b0, 1'b1, 1'b1, 15, 15, 15, 0);
         else       run_case("R3", 2'(p), 1'b0, 1'b1, 1'b1, 0, 0, 0, 0);
      end
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      #(4 * 100000);
      errs++;
      checks++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule